// File: doc/BRIEF.md
# Subscriber Line Ringing and Hook Supervisor

This block sits on the host side of a subscriber line interface circuit. It drives two of that circuit's control inputs: an active-high ring-mode line and an active-low power-down line. It also watches the circuit's switch-hook output. When the host raises a ring request, the block runs an on/off ringing cadence. It filters the hook signal so that only a steady off-hook counts. When the subscriber answers, ringing stops at once.

In idle, the host may let the block keep the line interface powered down. The block then wakes the interface at a fixed interval, lets it settle, and reads the hook. If the line is still on hook, it powers the interface down again. The hook input is ignored while the interface is starting up, because its outputs are not valid then.

The power-down line is never driven high. It is modelled as a pull-low enable for an open-drain pad. While the interface is awake, the same enable can instead carry a 64 kHz square wave that synchronises the interface's converter. All timing is built from a millisecond tick, which is divided down from the system clock. There are no data streams here, so every pin is a plain control or status level.

Top module: `ring_hook_ctrl`

## Requirements
- R1: While `ring_req` is high and no off-hook has been accepted, `ring_mode` alternates between RING_ON_MS ms high and RING_OFF_MS ms low, starting with a high burst. The first burst may be up to one millisecond short. Every later burst and gap is exact to the clock cycle. When `ring_req` is low, `ringing` is low on the next cycle.
- R2: `hook_in` is high for off-hook and low for on-hook. It is synchronised, and a change is accepted only after the new level has been held for DEBOUNCE_MS ms. A pulse shorter than DEBOUNCE_MS-1 ms is ignored. The same filter applies when the line goes back on hook.
- R3: When an off-hook is accepted during a ring request, `ring_mode` is low from the next clock edge on, and the cadence stays stopped until `ring_req` falls. If ringing was active, `answered` pulses high for exactly one cycle, with `off_hook` high and `ringing` low. A request made while already off hook never rings.
- R4: `ringing` is high whenever the cadence is running, in both bursts and gaps, and `ring_mode` is never high without it.
- R5: `pd_drive_low` is a pull-low enable only. With `pd_mode_en` and `sync_en` both low, and after startup, it stays low. It is also low while ringing unless sync is enabled.
- R6: After reset, and after each wake from power-down, the hook is ignored for at least STARTUP_MS ms. During that window `off_hook` holds its value.
- R7: With `pd_mode_en` high, no request and the line on hook, the block pulls the pin low for POLL_MS ms. It then releases the pin for (STARTUP_MS+1)+(DEBOUNCE_MS+1) ms: a startup window followed by a check window. It repeats this while the line stays on hook. An off-hook accepted in the check window keeps the interface awake, and going back on hook returns it to power-down.
- R8: With `sync_en` high and the interface awake, `pd_drive_low` is a 50% square wave whose half-period is CLK_HZ/128000 cycles, with a minimum of 1.
- R9: A ring request while powered down releases the pin within a few cycles. Ringing begins after the startup window.
- R10: `off_hook` is the filtered hook level and is low from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_req | input | 1 | Host request to ring the line |
| pd_mode_en | input | 1 | Allow power-down polling while idle |
| sync_en | input | 1 | Send the 64 kHz sync wave on the power-down pin while awake |
| hook_in | input | 1 | Raw switch-hook from the interface, high = off hook |
| ring_mode | output | 1 | Ring-mode drive, high = ringing burst |
| pd_drive_low | output | 1 | Pull-low enable for the open-drain power-down pin |
| off_hook | output | 1 | Filtered off-hook level |
| answered | output | 1 | One-cycle pulse when ringing is tripped by an answer |
| ringing | output | 1 | Cadence running |

## Verification
The assertions check on every cycle that an accepted off-hook drops `ring_mode` on the next edge. They also check that `answered` is a single-cycle pulse taken while off hook, that `ring_mode` stays inside `ringing`, that a withdrawn request stops ringing, that `off_hook` cannot move while the hook is masked, and that the pin is not pulled while ringing without sync. The lengths of bursts and gaps, the debounce latency window, glitch rejection, the timing of the polling sequence, and the shape of the sync wave depend on multi-millisecond durations, so only the bench scenarios show them. Those scenarios use a small configuration in which every duration is computed from the parameters.

// File: rtl/ring_hook_pkg.sv
package ring_hook_pkg;

  typedef enum logic [1:0] {
    PW_AWAKE = 2'd0,
    PW_DOWN  = 2'd1,
    PW_START = 2'd2,
    PW_CHECK = 2'd3
  } pwr_state_e;

  // width needed to hold values 0..v
  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rhc_tick_gen.sv
module rhc_tick_gen #(
  parameter int unsigned TICK_DIV  = 250000,
  parameter int unsigned SYNC_HALF = 1953
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick,
  output logic sync_wave
);
  localparam int unsigned TW = ring_hook_pkg::cnt_w(TICK_DIV - 1);
  localparam int unsigned SW = ring_hook_pkg::cnt_w(SYNC_HALF - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SYNC_HALF - 1);

  logic [TW-1:0] t_cnt;
  logic [SW-1:0] s_cnt;

  assign ms_tick = (t_cnt == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt <= '0;
    end else if (ms_tick) begin
      t_cnt <= '0;
    end else begin
      t_cnt <= t_cnt + 1'b1;
    end
  end

  // free-running square wave, toggles every SYNC_HALF cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cnt     <= '0;
      sync_wave <= 1'b0;
    end else if (s_cnt == S_LAST) begin
      s_cnt     <= '0;
      sync_wave <= ~sync_wave;
    end else begin
      s_cnt <= s_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rhc_hook_qual.sv
module rhc_hook_qual #(
  parameter int unsigned DEB_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic hook_valid,
  input  logic hook_raw,
  output logic off_hook
);
  localparam int unsigned CW = ring_hook_pkg::cnt_w(DEB_MS);
  localparam logic [CW-1:0] D_LAST = CW'(DEB_MS - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] d_cnt;
  logic          hook_s;

  assign hook_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], hook_raw};
  end

  // level accepted only after DEB_MS consecutive ticks at the new value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_hook <= 1'b0;
      d_cnt    <= '0;
    end else if (!hook_valid || (hook_s == off_hook)) begin
      d_cnt <= '0;
    end else if (ms_tick) begin
      if (d_cnt == D_LAST) begin
        off_hook <= hook_s;
        d_cnt    <= '0;
      end else begin
        d_cnt <= d_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rhc_power_seq.sv
module rhc_power_seq #(
  parameter int unsigned POLL_MS  = 1000,
  parameter int unsigned START_MS = 50,
  parameter int unsigned DEB_MS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pd_mode_en,
  input  logic ring_req,
  input  logic off_hook,
  output logic pd_low,
  output logic hook_valid,
  output logic awake
);
  import ring_hook_pkg::*;

  localparam int unsigned MAXV = umax(umax(POLL_MS, START_MS), DEB_MS + 1);
  localparam int unsigned CW   = cnt_w(MAXV);
  localparam logic [CW-1:0] P_LAST = CW'(POLL_MS - 1);
  localparam logic [CW-1:0] S_LAST = CW'(START_MS);
  localparam logic [CW-1:0] C_LAST = CW'(DEB_MS);

  pwr_state_e    st;
  logic [CW-1:0] cnt;
  logic          stay_up;

  assign stay_up    = !pd_mode_en || ring_req;
  assign pd_low     = (st == PW_DOWN);
  assign hook_valid = (st == PW_AWAKE) || (st == PW_CHECK);
  assign awake      = (st == PW_AWAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PW_START;
      cnt <= '0;
    end else begin
      unique case (st)
        PW_AWAKE: begin
          if (!stay_up && !off_hook) begin
            st  <= PW_DOWN;
            cnt <= '0;
          end
        end
        PW_DOWN: begin
          if (stay_up) begin
            st  <= PW_START;
            cnt <= '0;
          end else if (ms_tick) begin
            if (cnt == P_LAST) begin
              st  <= PW_START;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PW_START: begin
          // START_MS+1 ticks guarantees a full START_MS window
          if (ms_tick) begin
            if (cnt == S_LAST) begin
              st  <= PW_CHECK;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PW_CHECK: begin
          if (stay_up || off_hook) begin
            st  <= PW_AWAKE;
            cnt <= '0;
          end else if (ms_tick) begin
            if (cnt == C_LAST) begin
              st  <= PW_DOWN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          st  <= PW_START;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rhc_ring_cadence.sv
module rhc_ring_cadence #(
  parameter int unsigned ON_MS  = 1000,
  parameter int unsigned OFF_MS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic ring_req,
  input  logic ring_ok,
  input  logic off_hook,
  output logic ring_mode,
  output logic ringing,
  output logic answered
);
  localparam int unsigned CW = ring_hook_pkg::cnt_w(ring_hook_pkg::umax(ON_MS, OFF_MS));
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_MS - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_MS - 1);

  logic          active;
  logic          on_ph;
  logic          tripped;
  logic [CW-1:0] cnt;

  assign ring_mode = active && on_ph;
  assign ringing   = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      on_ph    <= 1'b0;
      tripped  <= 1'b0;
      cnt      <= '0;
      answered <= 1'b0;
    end else begin
      answered <= 1'b0;
      if (!ring_req) begin
        active  <= 1'b0;
        on_ph   <= 1'b0;
        tripped <= 1'b0;
        cnt     <= '0;
      end else if (tripped) begin
        active <= 1'b0;
      end else if (off_hook) begin
        tripped  <= 1'b1;
        active   <= 1'b0;
        answered <= active;
      end else if (!ring_ok) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (!active) begin
        active <= 1'b1;
        on_ph  <= 1'b1;
        cnt    <= '0;
      end else if (ms_tick) begin
        if (on_ph && (cnt == ON_LAST)) begin
          on_ph <= 1'b0;
          cnt   <= '0;
        end else if (!on_ph && (cnt == OFF_LAST)) begin
          on_ph <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ring_hook_ctrl.sv
module ring_hook_ctrl #(
  parameter int unsigned CLK_HZ      = 250000000,
  parameter int unsigned RING_ON_MS  = 1000,
  parameter int unsigned RING_OFF_MS = 3000,
  parameter int unsigned DEBOUNCE_MS = 10,
  parameter int unsigned STARTUP_MS  = 50,
  parameter int unsigned POLL_MS     = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_req,
  input  logic pd_mode_en,
  input  logic sync_en,
  input  logic hook_in,
  output logic ring_mode,
  output logic pd_drive_low,
  output logic off_hook,
  output logic answered,
  output logic ringing
);
  localparam int unsigned TICK_DIV  = CLK_HZ / 1000;
  localparam int unsigned SYNC_RAW  = CLK_HZ / 128000;
  localparam int unsigned SYNC_HALF = (SYNC_RAW < 1) ? 1 : SYNC_RAW;

  logic ms_tick;
  logic sync_wave;
  logic hook_valid;
  logic pd_low;
  logic awake;

  rhc_tick_gen #(.TICK_DIV(TICK_DIV), .SYNC_HALF(SYNC_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sync_wave(sync_wave)
  );

  rhc_hook_qual #(.DEB_MS(DEBOUNCE_MS)) u_hook (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .hook_valid(hook_valid),
    .hook_raw(hook_in), .off_hook(off_hook)
  );

  rhc_power_seq #(.POLL_MS(POLL_MS), .START_MS(STARTUP_MS), .DEB_MS(DEBOUNCE_MS)) u_pwr (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pd_mode_en(pd_mode_en),
    .ring_req(ring_req), .off_hook(off_hook), .pd_low(pd_low),
    .hook_valid(hook_valid), .awake(awake)
  );

  rhc_ring_cadence #(.ON_MS(RING_ON_MS), .OFF_MS(RING_OFF_MS)) u_ring (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ring_req(ring_req),
    .ring_ok(awake), .off_hook(off_hook), .ring_mode(ring_mode),
    .ringing(ringing), .answered(answered)
  );

  // registered pull-low enable keeps the pad free of decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_drive_low <= 1'b0;
    else        pd_drive_low <= pd_low || (sync_en && sync_wave);
  end
endmodule

// File: rtl/ring_hook_ctrl_chk.sv
module ring_hook_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ring_req,
  input logic sync_en,
  input logic off_hook,
  input logic ring_mode,
  input logic ringing,
  input logic answered,
  input logic pd_drive_low,
  input logic hook_valid
);
  p_trip_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (off_hook && ring_mode) |=> !ring_mode);

  p_answer_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    answered |=> !answered);

  p_answer_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    answered |-> (off_hook && !ringing));

  p_burst_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_mode |-> ringing);

  p_req_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_req |=> !ringing);

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hook_valid |=> $stable(off_hook));

  p_no_pull_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_mode && !$past(sync_en)) |-> !pd_drive_low);
endmodule

bind ring_hook_ctrl ring_hook_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .sync_en(sync_en),
  .off_hook(off_hook), .ring_mode(ring_mode), .ringing(ringing),
  .answered(answered), .pd_drive_low(pd_drive_low), .hook_valid(hook_valid)
);

// File: tb/ring_hook_ctrl_tb.sv
module ring_hook_ctrl_tb;
  localparam int CLK_HZ = 256000;
  localparam int T      = CLK_HZ / 1000;
  localparam int ON     = 4;
  localparam int OFF    = 12;
  localparam int DEB    = 3;
  localparam int STU    = 5;
  localparam int POLL   = 8;
  localparam int HALF   = CLK_HZ / 128000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_req = 1'b0, pd_mode_en = 1'b0, sync_en = 1'b0, hook_in = 1'b0;
  logic ring_mode, pd_drive_low, off_hook, answered, ringing;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ring_hook_ctrl #(.CLK_HZ(CLK_HZ), .RING_ON_MS(ON), .RING_OFF_MS(OFF),
    .DEBOUNCE_MS(DEB), .STARTUP_MS(STU), .POLL_MS(POLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .pd_mode_en(pd_mode_en),
    .sync_en(sync_en), .hook_in(hook_in), .ring_mode(ring_mode),
    .pd_drive_low(pd_drive_low), .off_hook(off_hook), .answered(answered),
    .ringing(ringing)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic sig(input int w);
    case (w)
      0:       return ring_mode;
      1:       return pd_drive_low;
      2:       return off_hook;
      3:       return answered;
      default: return ringing;
    endcase
  endfunction

  task automatic wait_for(input int w, input logic lvl, input int limit, output int lat);
    lat = 0;
    while (sig(w) !== lvl && lat < limit) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_len(input int w, input logic lvl, input int limit, output int len);
    len = 0;
    while (sig(w) === lvl && len < limit) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic count_hi(input int w, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (sig(w) === 1'b1) hi++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int lat, len, hi, lat2, tog;
    logic prev;
    cyc(5);
    // R10 / R5: reset values
    check(ring_mode == 0 && ringing == 0 && answered == 0, "R10 reset ring outputs",
          {ring_mode, ringing, answered}, 0);
    check(off_hook == 0, "R10 reset off_hook", off_hook, 0);
    check(pd_drive_low == 0, "R5 reset pd_drive_low", pd_drive_low, 0);

    // R6: hook masked during startup after reset
    rst_n = 1'b1;
    hook_in = 1'b1;
    count_hi(2, STU * T, hi);
    check(hi == 0, "R6 hook masked after reset", hi, 0);
    hook_in = 1'b0;
    cyc(3 * T);

    // R5: no pull with polling and sync off
    count_hi(1, 4 * T, hi);
    check(hi == 0, "R5 pin released when idle", hi, 0);

    // R1 / R4: cadence lengths
    ring_req = 1'b1;
    wait_for(0, 1'b1, 10, lat);
    check(lat <= 2, "R1 burst starts promptly", lat, 1);
    run_len(0, 1'b1, 2 * ON * T, len);
    check(len >= (ON - 1) * T + 1 && len <= ON * T, "R1 first burst length", len, ON * T);
    run_len(0, 1'b0, 2 * OFF * T, len);
    check(len == OFF * T, "R1 gap length", len, OFF * T);
    run_len(0, 1'b1, 2 * ON * T, len);
    check(len == ON * T, "R1 burst length", len, ON * T);
    check(ringing == 1, "R4 ringing during gap", ringing, 1);
    run_len(0, 1'b0, 2 * OFF * T, len);
    check(len == OFF * T, "R1 second gap length", len, OFF * T);
    check(ringing == 1, "R4 ringing during burst", ringing, 1);

    // R2: short hook glitch ignored
    hook_in = 1'b1;
    cyc((DEB - 1) * T - 4);
    hook_in = 1'b0;
    count_hi(2, 2 * DEB * T, hi);
    check(hi == 0, "R2 glitch rejected", hi, 0);
    check(ringing == 1, "R2 glitch does not trip", ringing, 1);

    // R3: answer at several points in the cadence
    for (int k = 0; k < 4; k++) begin
      ring_req = 1'b0;
      cyc(2);
      ring_req = 1'b1;
      cyc(k * 1100 + 13);
      hook_in = 1'b1;
      wait_for(2, 1'b1, DEB * T + 20, lat);
      check(lat >= (DEB - 1) * T + 1 && lat <= DEB * T + 3, "R2 debounce latency", lat, DEB * T);
      cyc(1);
      check(ring_mode == 0 && ringing == 0, "R3 ring drops next edge", {ring_mode, ringing}, 0);
      check(answered == 1, "R3 answered pulse", answered, 1);
      cyc(1);
      check(answered == 0, "R3 answered one cycle", answered, 0);
      count_hi(0, 3 * T, hi);
      check(hi == 0, "R3 cadence stopped", hi, 0);
      hook_in = 1'b0;
      wait_for(2, 1'b0, DEB * T + 20, lat2);
      check(lat2 >= (DEB - 1) * T + 1 && lat2 <= DEB * T + 3, "R2 release latency", lat2, DEB * T);
      count_hi(0, 2 * T, hi);
      check(hi == 0, "R3 stays tripped while requested", hi, 0);
      ring_req = 1'b0;
      cyc(2);
    end

    // R3: request while already off hook
    hook_in = 1'b1;
    wait_for(2, 1'b1, DEB * T + 20, lat);
    ring_req = 1'b1;
    count_hi(0, 2 * T, hi);
    count_hi(3, 2, lat);
    check(hi == 0 && lat == 0, "R3 no ring when off hook", hi + lat, 0);
    ring_req = 1'b0;
    hook_in = 1'b0;
    wait_for(2, 1'b0, DEB * T + 20, lat);

    // R7: polling sequence
    pd_mode_en = 1'b1;
    wait_for(1, 1'b1, 10, lat);
    check(lat <= 3, "R7 power down when idle", lat, 2);
    run_len(1, 1'b1, 2 * POLL * T, len);
    check(len >= (POLL - 1) * T + 1 && len <= POLL * T, "R7 first down time", len, POLL * T);
    run_len(1, 1'b0, 3 * (STU + DEB) * T, len);
    check(len == (STU + DEB + 2) * T, "R7 wake window", len, (STU + DEB + 2) * T);
    run_len(1, 1'b1, 2 * POLL * T, len);
    check(len == POLL * T, "R7 poll interval", len, POLL * T);

    // R6: hook masked during the wake startup
    hook_in = 1'b1;
    count_hi(2, STU * T, hi);
    check(hi == 0, "R6 hook masked after wake", hi, 0);
    wait_for(2, 1'b1, (DEB + 3) * T, lat);
    check(off_hook == 1, "R7 off hook seen in check window", off_hook, 1);
    count_hi(1, (POLL + 2) * T, hi);
    check(hi == 0, "R7 stays awake while off hook", hi, 0);
    hook_in = 1'b0;
    wait_for(1, 1'b1, (DEB + 1) * T + 10, lat);
    check(pd_drive_low == 1, "R7 back down after hang up", pd_drive_low, 1);

    // R9: ring request while powered down
    cyc(T);
    ring_req = 1'b1;
    wait_for(1, 1'b0, 5, lat);
    check(pd_drive_low == 0 && lat <= 3, "R9 wake on request", lat, 2);
    wait_for(0, 1'b1, (STU + 2) * T, lat2);
    lat2 = lat2 + lat;
    check(lat2 >= STU * T + 2 && lat2 <= (STU + 1) * T + 6, "R9 ring after startup", lat2, (STU + 1) * T);

    // R8: sync wave
    pd_mode_en = 1'b0;
    ring_req = 1'b0;
    cyc(10);
    sync_en = 1'b1;
    cyc(8);
    hi = 0;
    tog = 0;
    prev = pd_drive_low;
    for (int i = 0; i < 64; i++) begin
      if (pd_drive_low) hi++;
      if (pd_drive_low != prev) tog++;
      prev = pd_drive_low;
      @(negedge clk);
    end
    check(hi == 32, "R8 sync duty", hi, 32);
    check(tog == 64 / HALF || tog == 64 / HALF - 1, "R8 sync toggles", tog, 64 / HALF);
    sync_en = 1'b0;
    cyc(4);
    count_hi(1, 32, hi);
    check(hi == 0, "R5 release after sync off", hi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule